// File: doc/BRIEF.md
# Serial Peripheral Write Controller

This block turns one parallel word into a single serial write on a three-wire link made of an active-low chip select, a serial clock and a serial data line toward the peripheral. A client hands over a word by pulsing a start strobe for one system cycle while the block reports itself not busy. The block then lowers chip select and shifts the word out, most significant bit first, over exactly one serial clock period per bit. It then raises chip select and becomes ready again.

The serial clock idles low. Its period is a fixed number of system cycles, set by a parameter, and is split into equal low and high halves. Data changes only on the falling edge of the serial clock, so a peripheral that samples on the rising edge sees a bit that has been stable for half a period. A strobe that arrives while a write is in progress is dropped. A synchronous reset abandons any write and returns the link to idle.

Top module: `spi_write_ctrl`

## Requirements
- R1: A start strobe sampled while busy_o is low captures word_i. In the next cycle busy_o is 1 and cs_n_o is 0.
- R2: A start strobe sampled while busy_o is high is ignored. The frame in progress carries the original word and no extra frame follows.
- R3: While cs_n_o is low, exactly DATA_WIDTH rising edges of sclk_o occur.
- R4: Every low half and every high half of sclk_o inside a frame lasts DATA_CLK_PERIOD/2 system cycles, including the first low half after cs_n_o falls.
- R5: Whenever cs_n_o is high, sclk_o and mosi_o are both 0.
- R6: Bits leave most significant first. mosi_o changes only in the cycle where sclk_o falls and is constant while sclk_o is high.
- R7: busy_o is still 1 in the cycle where cs_n_o returns high and is 0 in the following cycle. busy_o low implies cs_n_o high.
- R8: rst held high for two or more cycles aborts any frame. In the cycle after the first reset edge, cs_n_o=1, sclk_o=0, busy_o=0 and mosi_o=0. The next strobe starts a complete frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | One-cycle strobe requesting a write |
| word_i | input | DATA_WIDTH | Word to send, captured with start_i |
| busy_o | output | 1 | High while a write is in progress |
| cs_n_o | output | 1 | Chip select, active low |
| sclk_o | output | 1 | Serial clock, idles low |
| mosi_o | output | 1 | Serial data toward the peripheral |

## Verification
Two cases are hard to reach from the ports: a strobe landing in the middle of a frame, and a reset cutting a frame short. The bench places both by counting system cycles from the accepted strobe, so each lands partway through the shifted bits. It then confirms at the ports that the frame in flight keeps the first word and that no phantom frame follows. After a reset, the bench checks that a new frame comes out whole. Back-to-back writes, issued as soon as busy_o drops, check the gap between frames.

// File: rtl/spi_wr_pkg.sv
package spi_wr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_TAIL  = 2'd2
    } spi_state_e;
endpackage

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == CW'(HALF - 1));
        cnt_d = (!run || tick) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end
endmodule

// File: rtl/spi_shift_out.sv
module spi_shift_out #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_word,
    input  logic         advance,
    output logic         msb
);
    logic [W-1:0] sr_d, sr_q;

    generate
        if (W == 1) begin : g_single
            always_comb sr_d = load ? load_word : sr_q;
        end else begin : g_multi
            always_comb begin
                if (load)         sr_d = load_word;
                else if (advance) sr_d = {sr_q[W-2:0], 1'b0};
                else              sr_d = sr_q;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) sr_q <= '0;
        else     sr_q <= sr_d;
    end

    assign msb = sr_q[W-1];
endmodule

// File: rtl/spi_write_ctrl.sv
module spi_write_ctrl
    import spi_wr_pkg::*;
#(
    parameter int DATA_WIDTH      = 8,
    parameter int DATA_CLK_PERIOD = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start_i,
    input  logic [DATA_WIDTH-1:0] word_i,
    output logic                  busy_o,
    output logic                  cs_n_o,
    output logic                  sclk_o,
    output logic                  mosi_o
);
    localparam int HALF = DATA_CLK_PERIOD / 2;
    localparam int BCW  = $clog2(DATA_WIDTH + 1);

    typedef struct packed {
        spi_state_e     state;
        logic           cs_n;
        logic           sclk;
        logic [BCW-1:0] bits;
    } ctrl_t;

    ctrl_t q, d;
    logic  tick, load, advance, msb, run;

    assign run = (q.state == ST_SHIFT);

    spi_half_timer #(.HALF(HALF)) u_timer (
        .clk (clk),
        .rst (rst),
        .run (run),
        .tick(tick)
    );

    spi_shift_out #(.W(DATA_WIDTH)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_word(word_i),
        .advance  (advance),
        .msb      (msb)
    );

    always_comb begin
        d       = q;
        load    = 1'b0;
        advance = 1'b0;
        case (q.state)
            ST_IDLE: begin
                if (start_i) begin
                    d.state = ST_SHIFT;
                    d.cs_n  = 1'b0;
                    d.sclk  = 1'b0;
                    d.bits  = '0;
                    load    = 1'b1;
                end
            end
            ST_SHIFT: begin
                if (tick) begin
                    if (!q.sclk) begin
                        d.sclk = 1'b1;
                    end else begin
                        d.sclk  = 1'b0;
                        advance = 1'b1;
                        if (q.bits == BCW'(DATA_WIDTH - 1)) begin
                            d.state = ST_TAIL;
                            d.cs_n  = 1'b1;
                        end else begin
                            d.bits = q.bits + 1'b1;
                        end
                    end
                end
            end
            ST_TAIL: d.state = ST_IDLE;
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '{state: ST_IDLE, cs_n: 1'b1, sclk: 1'b0, bits: '0};
        else     q <= d;
    end

    assign busy_o = (q.state != ST_IDLE);
    assign cs_n_o = q.cs_n;
    assign sclk_o = q.sclk;
    assign mosi_o = run ? msb : 1'b0;
endmodule

// File: rtl/spi_write_chk.sv
module spi_write_chk #(
    parameter int DATA_WIDTH      = 8,
    parameter int DATA_CLK_PERIOD = 4
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  start_i,
    input logic [DATA_WIDTH-1:0] word_i,
    input logic                  busy_o,
    input logic                  cs_n_o,
    input logic                  sclk_o,
    input logic                  mosi_o
);
    localparam int HALF = DATA_CLK_PERIOD / 2;

    int  hi_cnt, lo_cnt, rise_cnt;
    logic sclk_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_cnt <= 0; lo_cnt <= 0; rise_cnt <= 0; sclk_prev <= 1'b0;
        end else begin
            sclk_prev <= sclk_o;
            hi_cnt    <= sclk_o ? hi_cnt + 1 : 0;
            lo_cnt    <= (cs_n_o || sclk_o) ? 0 : lo_cnt + 1;
            if (cs_n_o)                   rise_cnt <= 0;
            else if (sclk_o && !sclk_prev) rise_cnt <= rise_cnt + 1;
        end
    end

    // R1
    accept_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> (busy_o && !cs_n_o));
    // R2
    no_restart_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n_o) |-> !$past(busy_o));
    // R3
    edge_count_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n_o) |-> (rise_cnt == DATA_WIDTH));
    // R4
    high_half_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sclk_o) |-> (hi_cnt == HALF));
    // R4
    low_half_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sclk_o) |-> (lo_cnt == HALF));
    // R5
    idle_lines_chk: assert property (@(posedge clk) disable iff (rst)
        cs_n_o |-> (!sclk_o && !mosi_o));
    // R6
    data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        sclk_o |-> $stable(mosi_o));
    // R7
    busy_tail_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n_o) |-> busy_o ##1 !busy_o);
    // R7
    busy_cover_chk: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> cs_n_o);
    // R8
    reset_idle_chk: assert property (@(posedge clk)
        $past(rst) |-> (cs_n_o && !sclk_o && !busy_o && !mosi_o));
endmodule

bind spi_write_ctrl spi_write_chk #(
    .DATA_WIDTH     (DATA_WIDTH),
    .DATA_CLK_PERIOD(DATA_CLK_PERIOD)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .start_i(start_i),
    .word_i (word_i),
    .busy_o (busy_o),
    .cs_n_o (cs_n_o),
    .sclk_o (sclk_o),
    .mosi_o (mosi_o)
);

// File: tb/sim_spi_write_ctrl.sv
module sim_spi_write_ctrl;
    localparam int DW   = 8;
    localparam int PER  = 4;
    localparam int HALF = PER / 2;
    localparam int NV   = 6;
    localparam logic [DW-1:0] VEC [NV] = '{8'hA5, 8'h00, 8'hFF, 8'h80, 8'h01, 8'h3C};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0;
    logic [DW-1:0] word_i = '0;
    logic busy_o, cs_n_o, sclk_o, mosi_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    spi_write_ctrl #(.DATA_WIDTH(DW), .DATA_CLK_PERIOD(PER)) u0 (
        .clk(clk), .rst(rst), .start_i(start_i), .word_i(word_i),
        .busy_o(busy_o), .cs_n_o(cs_n_o), .sclk_o(sclk_o), .mosi_o(mosi_o)
    );

    // bus monitor, sampled at the falling system edge
    logic          p_sclk = 1'b0, p_cs = 1'b1, p_mosi = 1'b0;
    logic [DW-1:0] acc = '0, last_word = '0;
    int            rises = 0, last_rises = 0, frames = 0, run_len = 0;
    int            bad_len = 0, bad_stab = 0;

    always @(negedge clk) begin
        if (!cs_n_o) begin
            if (p_cs) run_len = 1;
            else if (sclk_o == p_sclk) run_len = run_len + 1;
            else begin
                if (run_len != HALF) bad_len = bad_len + 1;
                run_len = 1;
            end
            if (sclk_o && !p_sclk) begin
                rises = rises + 1;
                acc = {acc[DW-2:0], mosi_o};
            end
            if (sclk_o && p_sclk && mosi_o != p_mosi) bad_stab = bad_stab + 1;
        end else if (!p_cs) begin
            if (p_sclk && run_len != HALF) bad_len = bad_len + 1;
            frames = frames + 1;
            last_word = acc;
            last_rises = rises;
            acc = '0;
            rises = 0;
        end
        p_sclk = sclk_o; p_cs = cs_n_o; p_mosi = mosi_o;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick_n(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
        end
    endtask

    task automatic send(input logic [DW-1:0] w);
        int guard = 0;
        tick_n(1);
        while (busy_o && guard < 1000) begin tick_n(1); guard++; end
        start_i = 1'b1; word_i = w;
        tick_n(1);
        start_i = 1'b0;
        chk(busy_o && !cs_n_o, "R1 busy/cs after accept", {busy_o, cs_n_o}, 2'b10);
    endtask

    task automatic wait_frame(input int f0);
        int guard = 0;
        while (frames == f0 && guard < 1000) begin tick_n(1); guard++; end
        chk(frames != f0, "R3 frame completes", frames, f0 + 1);
    endtask

    task automatic run_frame(input logic [DW-1:0] w);
        int f0 = frames;
        send(w);
        wait_frame(f0);
        chk(last_word == w, "R6 word msb first", last_word, w);
        chk(last_rises == DW, "R3 rising edges per frame", last_rises, DW);
        chk(busy_o == 1'b1, "R7 busy on cs release", busy_o, 1);
        chk(!sclk_o && !mosi_o, "R5 lines idle after frame", {sclk_o, mosi_o}, 0);
        tick_n(1);
        chk(busy_o == 1'b0, "R7 busy drop after cs", busy_o, 0);
        chk(bad_len == 0, "R4 half period length", bad_len, 0);
        chk(bad_stab == 0, "R6 data stable while sclk high", bad_stab, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual %0d expected %0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        tick_n(3);
        rst = 1'b0;
        tick_n(1);
        chk(cs_n_o && !sclk_o && !busy_o && !mosi_o, "R5 reset idle",
            {cs_n_o, sclk_o, busy_o, mosi_o}, 4'b1000);

        for (int v = 0; v < NV; v++) run_frame(VEC[v]);

        // R2: strobe mid-frame is ignored
        begin
            int f0;
            send(8'hC6);
            f0 = frames;
            tick_n(5);
            start_i = 1'b1; word_i = 8'h5A;
            tick_n(1);
            start_i = 1'b0;
            wait_frame(f0);
            chk(last_word == 8'hC6, "R2 mid-frame strobe ignored", last_word, 8'hC6);
            tick_n(20);
            chk(frames == f0 + 1 && cs_n_o && !busy_o, "R2 no extra frame",
                frames, f0 + 1);
        end

        // back to back
        run_frame(8'h69);
        run_frame(8'h96);

        // R8: reset mid-frame
        send(8'hE7);
        tick_n(9);
        rst = 1'b1;
        tick_n(1);
        chk(cs_n_o && !sclk_o && !busy_o && !mosi_o, "R8 reset aborts frame",
            {cs_n_o, sclk_o, busy_o, mosi_o}, 4'b1000);
        tick_n(1);
        rst = 1'b0;
        tick_n(2);
        chk(cs_n_o && !busy_o, "R8 idle after reset", {cs_n_o, busy_o}, 2'b10);
        bad_len = 0;
        run_frame(8'h4B);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule